// File: doc/BRIEF.md
# GPIO Port Data Register Pair

This block holds the output latches of a 24-pin general-purpose I/O port and presents them to the processor bus as two 16-bit data registers. The upper register carries pins 23..16 in its low byte, and its upper byte is reserved. The lower register carries pins 15..0. Pin direction and the choice between general I/O and a peripheral function are kept in registers outside this block and arrive as per-pin inputs. This block turns them into output enables and uses them to choose, bit by bit, what a read returns.

A pin set up as a general output drives its latch bit, and reading that bit returns the latch. For every other pin, a read returns the pin level after a two-flop synchronizer. A write to such a pin still updates its latch, so the value is ready when the pin is later turned into an output. The latches are cleared only by the external power-on reset. A watchdog reset blocks bus writes but keeps the stored data, and the data also survives sleep and standby while the clock is stopped.

Top module: `gpio_port_data`

## Requirements
- R1: While `por_n` is low, every latch bit and both synchronizer stages are 0, so `pin_out` is 0. The clear acts at once, without waiting for a clock edge.
- R2: While `wdt_rst` is 1, bus writes are ignored and the latches keep their value.
- R3: Access size code: 0 is byte, 1 is halfword, 2 and 3 are word. Read data is right-aligned and the unused upper bits are 0. A word read returns the upper register in bits 31..16 and the lower register in bits 15..0. A halfword read uses `bus_addr[1]`: 0 selects the upper register and 1 selects the lower register. A byte read uses `bus_addr` 0, 1, 2 and 3 to select the upper register's high byte, the upper register's low byte, the lower register's high byte and the lower register's low byte.
- R4: Byte and halfword writes take their data from `bus_wdata[7:0]` and `bus_wdata[15:0]`. They change only the addressed lanes, using the same lane map as R3.
- R5: The upper byte of the upper register always reads 0, and writes to it have no effect.
- R6: `pin_out[n]` always equals the latch bit of pin n. Pin n lies in bit n of the lower register for n < 16, and in bit n-16 of the upper register otherwise.
- R7: `pin_oe[n]` equals `pin_dir[n]` (1 = output) when `pin_func_gpio[n]` is 1, and is 0 when the pin belongs to a peripheral.
- R8: A read of a bit whose pin is a general output returns the latch, whatever level `pin_in` shows.
- R9: A read of any other bit returns the level `pin_in` had two rising clock edges earlier.
- R10: A write to a bit in input mode updates its latch. That value is returned by reads, and is driven with the output enable set, once the pin is switched to output.
- R11: Writes take effect on the rising edge where `bus_sel` and `bus_wr` are both 1, and at no other edge. Read data follows the address, size and pin mode without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | External power-on reset, active low, asynchronous |
| wdt_rst | input | 1 | Watchdog reset active; blocks writes, keeps data |
| bus_sel | input | 1 | Access to this register pair in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code (0 byte, 1 half, 2/3 word) |
| bus_addr | input | 2 | Byte offset within the pair |
| bus_wdata | input | 32 | Write data, right-aligned for narrow accesses |
| bus_rdata | output | 32 | Read data, right-aligned, combinational |
| pin_in | input | 24 | Raw pin levels |
| pin_dir | input | 24 | Per-pin direction, 1 = output |
| pin_func_gpio | input | 24 | Per-pin function select, 1 = general I/O |
| pin_out | output | 24 | Latch values toward the pads |
| pin_oe | output | 24 | Per-pin output enable |

## Verification
The read path is tried with all pins as outputs, all pins as inputs, all pins handed to a peripheral, and an alternating nibble pattern of directions. The all-output and all-input cases show whether the mux picks the latch or the pin. The peripheral case separates the direction input from the function select. The mixed case catches a mux that switches per register instead of per bit. While pins are inputs, reads are issued one and two edges after a pin change, which pins down the synchronizer depth. Narrow writes with distinct byte values at every offset expose lane swaps, and a long run of random accesses and mode changes is compared every cycle against a behavioural model.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;

    localparam int BUS_W  = 32;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = BUS_W / BYTE_W;

    typedef enum logic [1:0] {
        ACC_BYTE     = 2'd0,
        ACC_HALF     = 2'd1,
        ACC_WORD     = 2'd2,
        ACC_WORD_ALT = 2'd3
    } acc_size_e;

    // Bit position of a pin inside the 32-bit bus image of the pair.
    function automatic int pin_slot(input int pin, input int lo_bits);
        return (pin < lo_bits) ? pin : HALF_W + (pin - lo_bits);
    endfunction

    // Image bits that hold a real latch.
    function automatic logic [BUS_W-1:0] impl_mask(input int lo_bits, input int hi_bits);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int p = 0; p < lo_bits + hi_bits; p++) begin
            m[pin_slot(p, lo_bits)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            sync_d[k] = sync_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/gpio_bus_lanes.sv
`timescale 1ns/1ps
module gpio_bus_lanes
    import gpio_pkg::*;
(
    input  logic [1:0]       acc_size,
    input  logic [1:0]       acc_addr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] rimg,
    output logic [BUS_W-1:0] wmask,
    output logic [BUS_W-1:0] wimg,
    output logic [BUS_W-1:0] rdata
);

    acc_size_e        sz;
    logic [1:0]       lane_sel;
    logic [LANES-1:0] lane_en;

    assign sz       = acc_size_e'(acc_size);
    // Big-endian: offset 0 is the most significant lane.
    assign lane_sel = ~acc_addr;

    always_comb begin
        lane_en = '0;
        wimg    = wdata;
        rdata   = '0;
        case (sz)
            ACC_BYTE: begin
                lane_en[lane_sel]     = 1'b1;
                wimg                  = {LANES{wdata[BYTE_W-1:0]}};
                rdata[BYTE_W-1:0]     = rimg[lane_sel*BYTE_W +: BYTE_W];
            end
            ACC_HALF: begin
                if (acc_addr[1]) begin
                    lane_en[1:0] = 2'b11;
                end else begin
                    lane_en[3:2] = 2'b11;
                end
                wimg              = {2{wdata[HALF_W-1:0]}};
                rdata[HALF_W-1:0] = acc_addr[1] ? rimg[HALF_W-1:0] : rimg[BUS_W-1:HALF_W];
            end
            default: begin
                lane_en = '1;
                rdata   = rimg;
            end
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_mask
        assign wmask[l*BYTE_W +: BYTE_W] = {BYTE_W{lane_en[l]}};
    end

endmodule

// File: rtl/gpio_pin_mode.sv
`timescale 1ns/1ps
module gpio_pin_mode #(
    parameter int N = 24
) (
    input  logic [N-1:0] dir,
    input  logic [N-1:0] func_gpio,
    input  logic [N-1:0] latch,
    input  logic [N-1:0] synced,
    output logic [N-1:0] oe,
    output logic [N-1:0] rd_bits
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic drive_out;
        assign drive_out  = func_gpio[i] & dir[i];
        assign oe[i]      = drive_out;
        assign rd_bits[i] = drive_out ? latch[i] : synced[i];
    end

endmodule

// File: rtl/gpio_port_data.sv
`timescale 1ns/1ps
module gpio_port_data
    import gpio_pkg::*;
#(
    parameter int LO_BITS     = 16,
    parameter int HI_BITS     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       por_n,
    input  logic                       wdt_rst,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [1:0]                 bus_size,
    input  logic [1:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [LO_BITS+HI_BITS-1:0] pin_in,
    input  logic [LO_BITS+HI_BITS-1:0] pin_dir,
    input  logic [LO_BITS+HI_BITS-1:0] pin_func_gpio,
    output logic [LO_BITS+HI_BITS-1:0] pin_out,
    output logic [LO_BITS+HI_BITS-1:0] pin_oe
);

    localparam int              PIN_W = LO_BITS + HI_BITS;
    localparam logic [BUS_W-1:0] IMPL  = impl_mask(LO_BITS, HI_BITS);

    typedef struct packed {
        logic [PIN_W-1:0] data;
    } state_t;

    state_t            st_d, st_q;
    logic              wr_fire;
    logic [BUS_W-1:0]  wmask, wimg, rimg;
    logic [PIN_W-1:0]  synced, rd_bits;
    logic              unused_rsvd_lanes;

    gpio_in_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   (pin_in),
        .dout  (synced)
    );

    gpio_bus_lanes u_lanes (
        .acc_size (bus_size),
        .acc_addr (bus_addr),
        .wdata    (bus_wdata),
        .rimg     (rimg),
        .wmask    (wmask),
        .wimg     (wimg),
        .rdata    (bus_rdata)
    );

    gpio_pin_mode #(
        .N (PIN_W)
    ) u_mode (
        .dir       (pin_dir),
        .func_gpio (pin_func_gpio),
        .latch     (st_q.data),
        .synced    (synced),
        .oe        (pin_oe),
        .rd_bits   (rd_bits)
    );

    assign wr_fire = bus_sel & bus_wr & ~wdt_rst;

    // Lane bits over reserved positions have no latch behind them.
    assign unused_rsvd_lanes = ^((wmask | wimg) & ~IMPL);

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < PIN_W; p++) begin
            if (wr_fire && wmask[pin_slot(p, LO_BITS)]) begin
                st_d.data[p] = wimg[pin_slot(p, LO_BITS)];
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rimg = '0;
        for (int p = 0; p < PIN_W; p++) begin
            rimg[pin_slot(p, LO_BITS)] = rd_bits[p];
        end
    end

    assign pin_out = st_q.data;

endmodule

// File: rtl/gpio_port_data_chk.sv
`timescale 1ns/1ps
module gpio_port_data_chk
    import gpio_pkg::*;
#(
    parameter int LO_BITS = 16,
    parameter int HI_BITS = 8
) (
    input logic                       clk,
    input logic                       por_n,
    input logic                       wdt_rst,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic                       acc_word,
    input logic [31:0]                bus_wdata,
    input logic [31:0]                bus_rdata,
    input logic [LO_BITS+HI_BITS-1:0] pin_in,
    input logic [LO_BITS+HI_BITS-1:0] pin_dir,
    input logic [LO_BITS+HI_BITS-1:0] pin_func_gpio,
    input logic [LO_BITS+HI_BITS-1:0] pin_out,
    input logic [LO_BITS+HI_BITS-1:0] pin_oe
);

    localparam int               PIN_W = LO_BITS + HI_BITS;
    localparam logic [BUS_W-1:0] IMPL  = impl_mask(LO_BITS, HI_BITS);

    logic [1:0]       age;
    logic [BUS_W-1:0] out_img, oe_img, in_img, inmode_img;
    logic             word_rd, word_wr;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    always_comb begin
        out_img    = '0;
        oe_img     = '0;
        in_img     = '0;
        inmode_img = '0;
        for (int p = 0; p < PIN_W; p++) begin
            out_img[pin_slot(p, LO_BITS)]    = pin_out[p];
            oe_img[pin_slot(p, LO_BITS)]     = pin_oe[p];
            in_img[pin_slot(p, LO_BITS)]     = pin_in[p];
            inmode_img[pin_slot(p, LO_BITS)] = ~(pin_dir[p] & pin_func_gpio[p]);
        end
    end

    assign word_rd = bus_sel & ~bus_wr & acc_word;
    assign word_wr = bus_sel & bus_wr & ~wdt_rst & acc_word;

    always @(posedge clk) begin
        if (!por_n) begin
            p_por_clear_r1: assert (pin_out == '0);
        end
    end

    p_wdt_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst |=> $stable(pin_out));

    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!por_n)
        word_rd |-> ((bus_rdata & ~IMPL) == '0));

    p_word_write_r6: assert property (@(posedge clk) disable iff (!por_n)
        word_wr |=> (((out_img ^ $past(bus_wdata)) & IMPL) == '0));

    p_oe_gate_r7: assert property (@(posedge clk) disable iff (!por_n)
        ((pin_oe & ~(pin_dir & pin_func_gpio)) == '0));

    p_out_read_r8: assert property (@(posedge clk) disable iff (!por_n)
        word_rd |-> (((bus_rdata ^ out_img) & oe_img) == '0));

    p_in_read_r9: assert property (@(posedge clk) disable iff (!por_n)
        (word_rd && age >= 2'd2) |-> (((bus_rdata ^ $past(in_img, 2)) & inmode_img & IMPL) == '0));

    p_no_write_r11: assert property (@(posedge clk) disable iff (!por_n)
        !(bus_sel && bus_wr) |=> $stable(pin_out));

endmodule

bind gpio_port_data gpio_port_data_chk #(
    .LO_BITS (LO_BITS),
    .HI_BITS (HI_BITS)
) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .wdt_rst       (wdt_rst),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .acc_word      (bus_size[1]),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .pin_in        (pin_in),
    .pin_dir       (pin_dir),
    .pin_func_gpio (pin_func_gpio),
    .pin_out       (pin_out),
    .pin_oe        (pin_oe)
);

// File: tb/sim_gpio_port_data.sv
`timescale 1ns/1ps
module sim_gpio_port_data;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        wdt_rst = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_dir = '1;
    logic [23:0] pin_func_gpio = '1;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;

    int n_chk = 0;
    int n_err = 0;

    logic [23:0] m_data = '0;
    logic [23:0] hist[$];

    always #5 clk = ~clk;

    gpio_port_data u0 (
        .clk           (clk),
        .por_n         (por_n),
        .wdt_rst       (wdt_rst),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_size      (bus_size),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .pin_in        (pin_in),
        .pin_dir       (pin_dir),
        .pin_func_gpio (pin_func_gpio),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: per-pin latch, pin history of the last two edges.
    function automatic logic [31:0] exp_rdata();
        logic [23:0] sy;
        logic [23:0] outm;
        logic [31:0] img;
        sy   = (hist.size() == 2) ? hist[0] : 24'h0;
        outm = pin_dir & pin_func_gpio;
        img  = {8'h00, (m_data & outm) | (sy & ~outm)};
        case (bus_size)
            2'd0:    return (img >> (8 * (3 - int'(bus_addr)))) & 32'hFF;
            2'd1:    return bus_addr[1] ? (img & 32'hFFFF) : (img >> 16);
            default: return img;
        endcase
    endfunction

    task automatic model_write();
        for (int p = 0; p < 24; p++) begin
            bit   hit;
            logic b;
            case (bus_size)
                2'd0: begin
                    hit = ((p / 8) == (3 - int'(bus_addr)));
                    b   = bus_wdata[p % 8];
                end
                2'd1: begin
                    hit = bus_addr[1] ? (p < 16) : (p >= 16);
                    b   = bus_wdata[p % 16];
                end
                default: begin
                    hit = 1'b1;
                    b   = bus_wdata[p];
                end
            endcase
            if (hit) m_data[p] = b;
        end
    endtask

    always @(negedge por_n) begin
        m_data = '0;
        hist.delete();
    end

    always @(posedge clk) begin
        if (!por_n) begin
            m_data = '0;
            hist.delete();
        end else begin
            if (bus_sel && bus_wr && !wdt_rst) model_write();
            hist.push_back(pin_in);
            if (hist.size() > 2) void'(hist.pop_front());
        end
    end

    // Every-cycle comparison against the model (R6, R7, R3/R8/R9).
    always @(negedge clk) begin
        chk("R6 pin_out", {8'h0, pin_out}, {8'h0, m_data});
        chk("R7 pin_oe", {8'h0, pin_oe}, {8'h0, pin_dir & pin_func_gpio});
        if (bus_sel && !bus_wr) chk("R3/R8/R9 read", bus_rdata, exp_rdata());
    end

    task automatic drive(input logic s, input logic w, input logic [1:0] sz,
                         input logic [1:0] ad, input logic [31:0] wd);
        @(posedge clk);
        #2;
        bus_sel   = s;
        bus_wr    = w;
        bus_size  = sz;
        bus_addr  = ad;
        bus_wdata = wd;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 2'd0, 2'd0, 32'h0);
    endtask

    task automatic wr_op(input logic [1:0] sz, input logic [1:0] ad, input logic [31:0] wd);
        drive(1'b1, 1'b1, sz, ad, wd);
        idle();
    endtask

    task automatic rd_chk(input logic [1:0] sz, input logic [1:0] ad,
                          input logic [31:0] exp, input string tag);
        drive(1'b1, 1'b0, sz, ad, 32'h0);
        @(negedge clk);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL R11 watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        chk("R1 reset pin_out", {8'h0, pin_out}, 32'h0);
        repeat (2) @(posedge clk);
        #2 por_n = 1'b1;

        // R3 / R5 / R6: word write and lane reads, all pins general outputs
        wr_op(2'd2, 2'd0, 32'hFFA5_5AC3);
        chk("R6 pin_out after word write", {8'h0, pin_out}, 32'h00A5_5AC3);
        rd_chk(2'd2, 2'd0, 32'h00A5_5AC3, "R5 word read reserved byte");
        rd_chk(2'd0, 2'd0, 32'h0000_0000, "R5 byte offset 0");
        rd_chk(2'd0, 2'd1, 32'h0000_00A5, "R3 byte offset 1");
        rd_chk(2'd0, 2'd2, 32'h0000_005A, "R3 byte offset 2");
        rd_chk(2'd0, 2'd3, 32'h0000_00C3, "R3 byte offset 3");

        // R4: narrow writes touch only their lanes
        wr_op(2'd1, 2'd2, 32'hDEAD_1234);
        rd_chk(2'd2, 2'd0, 32'h00A5_1234, "R4 half write low register");
        wr_op(2'd0, 2'd1, 32'h0000_007E);
        rd_chk(2'd2, 2'd0, 32'h007E_1234, "R4 byte write offset 1");
        wr_op(2'd0, 2'd3, 32'h0000_0099);
        rd_chk(2'd2, 2'd0, 32'h007E_1299, "R4 byte write offset 3");
        wr_op(2'd0, 2'd0, 32'h0000_00FF);
        rd_chk(2'd2, 2'd0, 32'h007E_1299, "R5 write to reserved byte");
        rd_chk(2'd1, 2'd0, 32'h0000_007E, "R3 half read upper");
        rd_chk(2'd1, 2'd3, 32'h0000_1299, "R3 half read addr bit0 ignored");
        rd_chk(2'd3, 2'd2, 32'h007E_1299, "R3 size code 3 as word");

        // R8: output pins read the latch whatever the pin level
        pin_in = 24'h81_8181;
        repeat (3) idle();
        rd_chk(2'd2, 2'd0, 32'h007E_1299, "R8 output read ignores pins");

        // R9: input pins, two-edge synchronizer
        idle();
        pin_in  = 24'h00_0000;
        repeat (3) idle();
        pin_dir = 24'h00_0000;
        pin_in  = 24'hC0_FFEE;
        rd_chk(2'd2, 2'd0, 32'h0000_0000, "R9 one edge after pin change");
        rd_chk(2'd2, 2'd0, 32'h00C0_FFEE, "R9 two edges after pin change");

        // R10: write while input, then switch to output
        wr_op(2'd2, 2'd0, 32'h0012_3456);
        chk("R6 latch drives pin_out in input mode", {8'h0, pin_out}, 32'h0012_3456);
        chk("R7 oe low for inputs", {8'h0, pin_oe}, 32'h0);
        rd_chk(2'd2, 2'd0, 32'h00C0_FFEE, "R9 input read after write");
        pin_dir = 24'hFF_FFFF;
        rd_chk(2'd2, 2'd0, 32'h0012_3456, "R10 latch visible after switch");
        chk("R10 oe after switch", {8'h0, pin_oe}, 32'h00FF_FFFF);

        // R7: peripheral function, then mixed per-bit pattern
        pin_func_gpio = 24'h00_0000;
        rd_chk(2'd2, 2'd0, 32'h00C0_FFEE, "R7 peripheral pins read pins");
        chk("R7 oe low for peripheral", {8'h0, pin_oe}, 32'h0);
        pin_func_gpio = 24'hFF_FFFF;
        pin_dir       = 24'hF0_F0F0;
        rd_chk(2'd2, 2'd0, 32'h0010_3F5E, "R8/R9 mixed per-bit modes");
        chk("R7 mixed oe", {8'h0, pin_oe}, 32'h00F0_F0F0);
        pin_dir = 24'hFF_FFFF;

        // R2: watchdog reset blocks writes, keeps data
        idle();
        wdt_rst = 1'b1;
        wr_op(2'd2, 2'd0, 32'h0000_0000);
        rd_chk(2'd2, 2'd0, 32'h0012_3456, "R2 write during watchdog reset");
        idle();
        wdt_rst = 1'b0;
        rd_chk(2'd2, 2'd0, 32'h0012_3456, "R2 data kept after watchdog reset");

        // R11: write strobe without select
        drive(1'b0, 1'b1, 2'd2, 2'd0, 32'h0000_0000);
        idle();
        chk("R11 no write without select", {8'h0, pin_out}, 32'h0012_3456);

        // R1: power-on reset mid-run clears at once
        por_n = 1'b0;
        @(negedge clk);
        chk("R1 async clear", {8'h0, pin_out}, 32'h0);
        idle();
        por_n = 1'b1;
        rd_chk(2'd2, 2'd0, 32'h0000_0000, "R1 read after power-on reset");

        // Random traffic against the model
        for (int c = 0; c < 600; c++) begin
            @(posedge clk);
            #2;
            bus_sel   = ($urandom_range(0, 3) != 0);
            bus_wr    = $urandom_range(0, 1) == 1;
            bus_size  = 2'($urandom_range(0, 3));
            bus_addr  = 2'($urandom_range(0, 3));
            bus_wdata = $urandom;
            pin_in    = 24'($urandom);
            wdt_rst   = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 7) == 0) pin_dir = 24'($urandom);
            if ($urandom_range(0, 15) == 0) pin_func_gpio = 24'($urandom);
        end
        idle();
        wdt_rst = 1'b0;
        idle();
        finish_run();
    end

endmodule